// File: doc/BRIEF.md
# Buffered Block-Transfer DMA Channel

This block moves a block of words between one peripheral and a contiguous region of memory. The memory address and the remaining word count are held in the block itself, so no processor work is needed per word. Each word costs exactly one memory reference: the data move. A processor-driven loop would also need an instruction fetch and a pointer and count update for every word.

Software loads a start address, a word count and a direction, then pulses the start command. In the device-to-memory direction, the channel accepts words on a ready/valid input stream into a small FIFO. It writes each buffered word to the next memory address. In the memory-to-device direction, it reads successive addresses into the FIFO and presents the words on a ready/valid output stream. When the last word has passed through both sides, the channel pulses `done` and returns to idle.

A start command that arrives while a transfer is running does not disturb that transfer. It sets an error flag that stays set until reset.

Top module: `bxc_channel`

## Requirements
- R1: A start command accepted while idle with a nonzero count raises `busy` in the cycle after the start edge, and the first memory reference uses the loaded start address.
- R2: Successive memory references use consecutive addresses, start, start+1 and so on, wrapping modulo 2^18. Exactly one reference is made per word.
- R3: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle in which `mem_ack` is high. The address advances only on such a cycle.
- R4: With `cmd_dir` = 0 (device to memory), every reference is a write (`mem_we` = 1). The written data follow the order in which words were accepted on the device input.
- R5: With `cmd_dir` = 1 (memory to device), every reference is a read (`mem_we` = 0). The word returned with each acknowledge is delivered on the device output in address order.
- R6: The buffer holds 4 words. With 4 words buffered, `dev_in_ready` is low in input mode and `mem_req` is low in output mode. Output mode therefore reads at most 4 words ahead of the device.
- R7: After the final word is transferred, `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R8: A start command with a count of 0 produces `done` in the cycle after the start edge. It makes no memory request and never raises `busy`.
- R9: While idle (`busy` low), `mem_req`, `dev_in_ready` and `dev_out_valid` are low. Device input words are not consumed.
- R10: A start command while `busy` is high leaves the running transfer unchanged and sets `err`. `err` stays high until reset, including across later accepted starts.
- R11: During reset, `busy`, `done`, `err` and `mem_req` are low.
- R12: Each transfer makes exactly as many acknowledged memory references as its loaded count, and no request follows the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse; loads the command fields when idle |
| cmd_dir | input | 1 | 0 = device to memory, 1 = memory to device |
| cmd_addr | input | 18 | Start address of the block |
| cmd_count | input | 12 | Number of words to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse (interrupt) |
| err | output | 1 | Sticky flag: start received while busy |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 18 | Memory address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Memory acknowledge; completes the reference at this edge |
| mem_rdata | input | 36 | Read data, valid with `mem_ack` |
| dev_in_valid | input | 1 | Device input word valid |
| dev_in_data | input | 36 | Device input word |
| dev_in_ready | output | 1 | Channel accepts a device input word |
| dev_out_valid | output | 1 | Channel presents a word to the device |
| dev_out_data | output | 36 | Word to the device |
| dev_out_ready | input | 1 | Device accepts the output word |

## Verification
A pointer that skips, or advances without an acknowledge, shows at the very next memory reference as an address that breaks the expected sequence. Counters that disagree with each other show at the end of the block. Either `done` fires before every word has crossed both sides, or it never fires, or one reference too many appears. A FIFO level that is wrong shows within a few cycles when the memory or the device is held back. Either `dev_in_ready` or `mem_req` stays high with four words already buffered, or a word reaches the far side out of order.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    localparam int BXC_ADDR_W = 18;
    localparam int BXC_CNT_W  = 12;
    localparam int BXC_DATA_W = 36;
    localparam int BXC_DEPTH  = 4;

    typedef enum logic {
        DIR_TO_MEM = 1'b0,
        DIR_TO_DEV = 1'b1
    } bxc_dir_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } bxc_phase_e;

    function automatic int bxc_lvl_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int bxc_ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/bxc_fifo.sv
module bxc_fifo
    import bxc_pkg::*;
#(
    parameter int DATA_W = BXC_DATA_W,
    parameter int DEPTH  = BXC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = bxc_ptr_bits(DEPTH);
    localparam int LVL_W = bxc_lvl_bits(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [LVL_W-1:0]  level;

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

endmodule

// File: rtl/bxc_ctrl.sv
module bxc_ctrl
    import bxc_pkg::*;
#(
    parameter int ADDR_W = BXC_ADDR_W,
    parameter int CNT_W  = BXC_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bxc_dir_e          dir_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              mem_fire,
    input  logic              dev_fire,
    output logic              busy,
    output bxc_dir_e          dir,
    output logic [ADDR_W-1:0] ptr,
    output logic              mem_left_nz,
    output logic              dev_left_nz,
    output logic              done,
    output logic              err
);
    bxc_phase_e       phase;
    logic [CNT_W-1:0] mem_left;
    logic [CNT_W-1:0] dev_left;
    logic [CNT_W-1:0] mem_left_nxt;
    logic [CNT_W-1:0] dev_left_nxt;
    logic             accept;
    logic             finish;

    assign busy        = (phase == PH_RUN);
    assign mem_left_nz = (mem_left != '0);
    assign dev_left_nz = (dev_left != '0);
    assign accept      = start && !busy;

    always_comb begin
        mem_left_nxt = mem_left - CNT_W'(mem_fire);
        dev_left_nxt = dev_left - CNT_W'(dev_fire);
        finish       = busy && (mem_left_nxt == '0) && (dev_left_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            dir      <= DIR_TO_MEM;
            ptr      <= '0;
            mem_left <= '0;
            dev_left <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && busy) begin
                err <= 1'b1;
            end
            if (accept) begin
                dir      <= dir_in;
                ptr      <= addr_in;
                mem_left <= count_in;
                dev_left <= count_in;
                if (count_in == '0) begin
                    done <= 1'b1;
                end else begin
                    phase <= PH_RUN;
                end
            end else if (busy) begin
                if (mem_fire) begin
                    ptr <= ptr + 1'b1;
                end
                mem_left <= mem_left_nxt;
                dev_left <= dev_left_nxt;
                if (finish) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    assert_start_loads_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && count_in != '0) |=> (busy && ptr == $past(addr_in)));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_fire && !finish) |=> (ptr == $past(ptr) + 1'b1));

    assert_no_extra_ref_R12: assert property (@(posedge clk) disable iff (rst)
        mem_fire |-> mem_left_nz);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && count_in == '0) |=> (done && !busy));

    assert_busy_start_err_R10: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_busy_start_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !mem_fire) |=> $stable(ptr));

endmodule

// File: rtl/bxc_steer.sv
module bxc_steer
    import bxc_pkg::*;
#(
    parameter int DATA_W = BXC_DATA_W
) (
    input  logic              busy,
    input  bxc_dir_e          dir,
    input  logic              mem_left_nz,
    input  logic              dev_left_nz,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_push_data,
    output logic              fifo_pop,
    output logic              mem_fire,
    output logic              dev_fire
);
    always_comb begin
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_wdata      = '0;
        dev_in_ready   = 1'b0;
        dev_out_valid  = 1'b0;
        dev_out_data   = '0;
        fifo_push      = 1'b0;
        fifo_push_data = '0;
        fifo_pop       = 1'b0;
        dev_fire       = 1'b0;
        if (busy) begin
            if (dir == DIR_TO_MEM) begin
                dev_in_ready   = dev_left_nz && !fifo_full;
                fifo_push      = dev_in_valid && dev_in_ready;
                fifo_push_data = dev_in_data;
                mem_req        = mem_left_nz && !fifo_empty;
                mem_we         = mem_req;
                mem_wdata      = mem_req ? fifo_head : '0;
                fifo_pop       = mem_req && mem_ack;
                dev_fire       = fifo_push;
            end else begin
                mem_req        = mem_left_nz && !fifo_full;
                fifo_push      = mem_req && mem_ack;
                fifo_push_data = mem_rdata;
                dev_out_valid  = !fifo_empty;
                dev_out_data   = fifo_head;
                fifo_pop       = dev_out_valid && dev_out_ready;
                dev_fire       = fifo_pop;
            end
        end
        mem_fire = mem_req && mem_ack;
    end

endmodule

// File: rtl/bxc_channel.sv
module bxc_channel
    import bxc_pkg::*;
#(
    parameter int ADDR_W = BXC_ADDR_W,
    parameter int CNT_W  = BXC_CNT_W,
    parameter int DATA_W = BXC_DATA_W,
    parameter int DEPTH  = BXC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_dir,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready
);
    bxc_dir_e          dir;
    bxc_dir_e          dir_cmd;
    logic              mem_left_nz;
    logic              dev_left_nz;
    logic              mem_fire;
    logic              dev_fire;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_full;
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [DATA_W-1:0] fifo_push_data;

    assign dir_cmd = bxc_dir_e'(cmd_dir);

    bxc_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (cmd_start),
        .dir_in      (dir_cmd),
        .addr_in     (cmd_addr),
        .count_in    (cmd_count),
        .mem_fire    (mem_fire),
        .dev_fire    (dev_fire),
        .busy        (busy),
        .dir         (dir),
        .ptr         (mem_addr),
        .mem_left_nz (mem_left_nz),
        .dev_left_nz (dev_left_nz),
        .done        (done),
        .err         (err)
    );

    bxc_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data (fifo_push_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    bxc_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .busy           (busy),
        .dir            (dir),
        .mem_left_nz    (mem_left_nz),
        .dev_left_nz    (dev_left_nz),
        .fifo_full      (fifo_full),
        .fifo_empty     (fifo_empty),
        .fifo_head      (fifo_head),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .dev_in_valid   (dev_in_valid),
        .dev_in_data    (dev_in_data),
        .dev_out_ready  (dev_out_ready),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_wdata      (mem_wdata),
        .dev_in_ready   (dev_in_ready),
        .dev_out_valid  (dev_out_valid),
        .dev_out_data   (dev_out_data),
        .fifo_push      (fifo_push),
        .fifo_push_data (fifo_push_data),
        .fifo_pop       (fifo_pop),
        .mem_fire       (mem_fire),
        .dev_fire       (dev_fire)
    );

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_addr_waits_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack && !cmd_start) |=> $stable(mem_addr));

    assert_write_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && dir == DIR_TO_MEM) |-> mem_we);

    assert_read_dir_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && dir == DIR_TO_DEV) |-> !mem_we);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !dev_in_ready && !dev_out_valid));

    assert_reset_state_R11: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !err && !mem_req));

endmodule

// File: tb/bxc_channel_bench.sv
`timescale 1ns/1ps
module bxc_channel_bench;
    localparam int AW    = 18;
    localparam int CW    = 12;
    localparam int DW    = 36;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_start;
    logic          cmd_dir;
    logic [AW-1:0] cmd_addr;
    logic [CW-1:0] cmd_count;
    logic          busy, done, err;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          dev_in_valid, dev_in_ready;
    logic [DW-1:0] dev_in_data;
    logic          dev_out_valid, dev_out_ready;
    logic [DW-1:0] dev_out_data;

    always #4 clk = ~clk;

    bxc_channel u_bxc_channel (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .busy(busy), .done(done), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] mem_arr [0:1023];
    logic [AW-1:0] exp_addr_q [$];
    logic [DW-1:0] exp_data_q [$];
    logic [DW-1:0] src_q [$];
    bit            src_en, sink_en, mode_out, pend, prev_done, idle_leak;
    int            mem_lat, lat_cnt, refs, acc, ack_cnt, dlv, peak, done_cnt, cyc;
    logic [AW-1:0] pend_addr, first_addr;
    logic          pend_we;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Environment: memory model, device source and sink, scoreboard monitor.
    always @(negedge clk) begin
        int level;
        if (rst) begin
            mem_ack = 1'b0; mem_rdata = '0; dev_in_valid = 1'b0; dev_in_data = '0;
            dev_out_ready = 1'b0; pend = 0; lat_cnt = 0; prev_done = 0;
        end else begin
            if (done) begin
                done_cnt++;
                check(!busy, "R7 busy low with done", busy, 0);
                check(!prev_done, "R7 done lasts one cycle", 1, 0);
            end
            prev_done = done;
            if (!busy && (mem_req || dev_in_ready || dev_out_valid)) idle_leak = 1;
            if (pend)
                check(mem_req && mem_addr == pend_addr && mem_we == pend_we,
                      "R3 request held until ack", mem_addr, pend_addr);
            level = mode_out ? (ack_cnt - dlv) : (acc - ack_cnt);
            if (level > peak) peak = level;
            if (level == DEPTH) begin
                if (mode_out) check(!mem_req, "R6 no read with buffer full", mem_req, 0);
                else          check(!dev_in_ready, "R6 device stalled with buffer full", dev_in_ready, 0);
            end
            mem_ack = 1'b0;
            pend = 0;
            if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    lat_cnt = 0;
                    refs++;
                    ack_cnt++;
                    if (refs == 1) first_addr = mem_addr;
                    if (exp_addr_q.size() == 0) check(0, "R12 unexpected memory reference", mem_addr, 0);
                    else begin
                        logic [AW-1:0] ea;
                        ea = exp_addr_q.pop_front();
                        check(mem_addr == ea, "R2 address sequence", mem_addr, ea);
                    end
                    if (mem_we) begin
                        check(!mode_out, "R4 write only in input mode", mem_we, 0);
                        if (exp_data_q.size() == 0) check(0, "R4 unexpected write", mem_wdata, 0);
                        else begin
                            logic [DW-1:0] ed;
                            ed = exp_data_q.pop_front();
                            check(mem_wdata == ed, "R4 write data order", mem_wdata, ed);
                        end
                        mem_arr[mem_addr[9:0]] = mem_wdata;
                    end else begin
                        check(mode_out, "R5 read only in output mode", mem_we, 1);
                        mem_rdata = mem_arr[mem_addr[9:0]];
                    end
                end else begin
                    lat_cnt++;
                    pend = 1; pend_addr = mem_addr; pend_we = mem_we;
                end
            end
            if (src_en && src_q.size() > 0) begin
                dev_in_valid = 1'b1;
                dev_in_data  = src_q[0];
                if (dev_in_ready) begin
                    void'(src_q.pop_front());
                    acc++;
                end
            end else begin
                dev_in_valid = 1'b0;
            end
            dev_out_ready = sink_en && (cyc % 4 != 3);
            if (dev_out_valid && dev_out_ready) begin
                dlv++;
                if (exp_data_q.size() == 0) check(0, "R5 unexpected device word", dev_out_data, 0);
                else begin
                    logic [DW-1:0] ed;
                    ed = exp_data_q.pop_front();
                    check(dev_out_data == ed, "R5 device data order", dev_out_data, ed);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic clear_counts();
        refs = 0; acc = 0; ack_cnt = 0; dlv = 0; peak = 0;
    endtask

    task automatic start_cmd(input bit dir, input logic [AW-1:0] addr, input int cnt);
        @(negedge clk);
        cmd_start = 1'b1; cmd_dir = dir; cmd_addr = addr; cmd_count = CW'(cnt);
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic push_input(input logic [AW-1:0] addr, input int n, input logic [7:0] tag);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] d;
            d = {tag, 12'h0, 16'(i * 37 + 5)};
            src_q.push_back(d);
            exp_addr_q.push_back(AW'(addr + AW'(i)));
            exp_data_q.push_back(d);
        end
    endtask

    task automatic push_output(input logic [AW-1:0] addr, input int n);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'(addr + AW'(i));
            d = {4'hA, 16'(i * 91 + 3), 16'(a)};
            mem_arr[a[9:0]] = d;
            exp_addr_q.push_back(a);
            exp_data_q.push_back(d);
        end
    endtask

    task automatic wait_done(input string tag);
        int d0;
        d0 = done_cnt;
        for (int i = 0; i < 3000 && done_cnt == d0; i++) @(negedge clk);
        check(done_cnt == d0 + 1, tag, done_cnt - d0, 1);
    endtask

    initial begin
        int d0;
        rst = 1'b1; cmd_start = 0; cmd_dir = 0; cmd_addr = '0; cmd_count = '0;
        src_en = 0; sink_en = 0; mode_out = 0; mem_lat = 0; done_cnt = 0; cyc = 0;
        idle_leak = 0; clear_counts();
        repeat (3) @(negedge clk);
        check(!busy, "R11 busy low in reset", busy, 0);
        check(!done, "R11 done low in reset", done, 0);
        check(!err,  "R11 err low in reset", err, 0);
        check(!mem_req, "R11 no request in reset", mem_req, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Input mode, slow memory, with a start issued mid-transfer.
        clear_counts(); mode_out = 0; mem_lat = 3;
        push_input(18'h00100, 6, 8'h5A);
        src_en = 1;
        start_cmd(0, 18'h00100, 6);
        check(busy, "R1 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        start_cmd(1, 18'h00300, 2);
        check(err, "R10 err set by start while busy", err, 1);
        check(busy, "R10 running transfer continues", busy, 1);
        wait_done("R7 done after input block");
        check(first_addr == 18'h00100, "R1 first reference at start address", first_addr, 18'h00100);
        check(refs == 6, "R12 one reference per word (input)", refs, 6);
        check(exp_addr_q.size() == 0, "R2 all addresses seen", exp_addr_q.size(), 0);
        check(peak == DEPTH, "R6 buffer fills to four", peak, DEPTH);

        // Idle: device words must not be consumed.
        idle_leak = 0;
        src_q.push_back(36'h111); src_q.push_back(36'h222);
        repeat (6) @(negedge clk);
        check(src_q.size() == 2, "R9 idle leaves device words", src_q.size(), 2);
        check(!idle_leak, "R9 idle outputs quiet", idle_leak, 0);
        check(refs == 6, "R9 no memory reference while idle", refs, 6);
        src_en = 0; src_q.delete();

        // Input mode crossing the top of the address space.
        clear_counts(); mem_lat = 0;
        push_input(18'h3FFFE, 3, 8'hC3);
        src_en = 1;
        start_cmd(0, 18'h3FFFE, 3);
        wait_done("R7 done after wrapping block");
        check(refs == 3, "R2 wrap block reference count", refs, 3);
        check(exp_data_q.size() == 0, "R4 all words written", exp_data_q.size(), 0);
        check(mem_arr[0] == {8'hC3, 12'h0, 16'(2 * 37 + 5)}, "R2 wrapped to address 0",
              mem_arr[0], {8'hC3, 12'h0, 16'(2 * 37 + 5)});
        src_en = 0;

        // Output mode, device held off at first.
        clear_counts(); mode_out = 1; mem_lat = 1; sink_en = 0;
        push_output(18'h00200, 5);
        start_cmd(1, 18'h00200, 5);
        repeat (20) @(negedge clk);
        check(dlv == 0, "R5 nothing delivered while device stalls", dlv, 0);
        check(ack_cnt == DEPTH, "R6 at most four reads ahead", ack_cnt, DEPTH);
        sink_en = 1;
        wait_done("R7 done after output block");
        check(dlv == 5, "R5 all words delivered", dlv, 5);
        check(refs == 5, "R12 one reference per word (output)", refs, 5);
        check(exp_data_q.size() == 0, "R5 scoreboard drained", exp_data_q.size(), 0);
        sink_en = 0;
        repeat (2) @(negedge clk);
        check(!mem_req, "R12 no request after last word", mem_req, 0);

        // Zero count.
        clear_counts(); mode_out = 0; d0 = done_cnt;
        start_cmd(0, 18'h00050, 0);
        check(done, "R8 done right after zero-count start", done, 1);
        check(!busy, "R8 busy stays low", busy, 0);
        check(!mem_req, "R8 no request", mem_req, 0);
        @(negedge clk);
        check(!done, "R8 done is a single pulse", done, 0);
        check(refs == 0 && done_cnt == d0 + 1, "R8 no references", refs, 0);
        check(err, "R10 err stays set", err, 1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule